// File: doc/BRIEF.md
# Page Translation Cache with Context Flush

This block caches recent virtual-to-physical page translations for a paging memory management unit. A 20-bit virtual page number, together with the current process identifier, is looked up against every stored entry at once. A hit returns the 20-bit physical page number and the page's permission flags in the same cycle. A miss raises a request to the page-table walker. The walker later returns its result as a fill, and the block stores that result as a new entry.

Software marks a context switch by writing the page-directory base register. That write invalidates every entry. A parameter turns on per-process tagging. In that mode each entry also carries a process identifier: only entries of the asking process can hit, and a separate invalidate command removes only one process's entries. Placement fills a free slot first, taking the lowest index. When every slot is valid, a round-robin pointer picks the victim. Permission checking is left to the consumer of the flags.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so a lookup reports no hit, the round-robin pointer is at slot 0, and the first fills take slots from index 0 upward.
- R2: A lookup hits when a valid entry has an equal page number and, with tagging on, an equal process identifier. In the same cycle `lk_hit` is 1, `lk_ppn` gives the stored physical page and `lk_flags` gives the stored flags, encoded bit 0 = dirty, bit 1 = writable, bit 2 = user-accessible. At most one entry matches.
- R3: When `lk_req` is 1 and the lookup misses, `walk_req` is 1; otherwise `walk_req` is 0. On a miss `lk_ppn` and `lk_flags` are 0.
- R4: A fill whose key matches no valid entry is written into the lowest-indexed invalid slot. It is visible to lookups from the next cycle.
- R5: If every slot is valid, a fill replaces the slot at the round-robin pointer. The pointer then advances by one and wraps from the last slot to 0. It does not move on fills that find a free or matching slot.
- R6: A fill whose page number (and, with tagging on, process identifier) matches a valid entry rewrites that entry in place, so no duplicate is created.
- R7: A base-register write (`base_wr` = 1) clears every entry's valid bit on the next edge, whatever the process identifiers are.
- R8: With tagging on, `inv_en` clears only the entries whose identifier equals `inv_pid`. With tagging off, `inv_en` clears every entry.
- R9: A fill in the same cycle as `base_wr` or `inv_en` is dropped: it creates and rewrites no entry, and it does not move the pointer.
- R10: With tagging off, the process identifier plays no part in hits or fill matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup is live this cycle |
| lk_vpn | input | 20 | Virtual page number looked up |
| lk_pid | input | 4 | Process identifier of the lookup |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_ppn | output | 20 | Physical page number on a hit, else 0 |
| lk_flags | output | 3 | {user, writable, dirty} on a hit, else 0 |
| walk_req | output | 1 | Live lookup missed; walker must fetch |
| fill_en | input | 1 | Walker result present |
| fill_vpn | input | 20 | Page number of the fill |
| fill_pid | input | 4 | Process identifier of the fill |
| fill_ppn | input | 20 | Physical page number of the fill |
| fill_flags | input | 3 | Flags of the fill, same encoding as lk_flags |
| base_wr | input | 1 | Page-directory base write: flush all |
| inv_en | input | 1 | Invalidate entries of one process |
| inv_pid | input | 4 | Process identifier to invalidate |

## Verification
The hardest case to reach from the ports is replacement with a pointer that has already wrapped, mixed with selective invalidation. To get there, every slot must be valid, more fills must follow than there are slots, and an invalidation must then punch holes that later fills have to find ahead of the pointer. The stimulus first runs forty distinct fills into an empty cache and then removes one process's entries. After that come long stretches of seeded mixed traffic over a small page and identifier range, so that matches, rewrites, holes and collisions of fill with flush occur often. A tagged instance and an untagged instance run side by side on the same stimulus.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int PID_W = 4;
  localparam int FLG_W = 3;

  typedef struct packed {
    logic             valid;
    logic [PID_W-1:0] pid;
    logic [VPN_W-1:0] vpn;
    logic [FLG_W-1:0] flags;
    logic [PPN_W-1:0] ppn;
  } tlb_entry_t;

  function automatic logic key_eq(input tlb_entry_t e, input logic [VPN_W-1:0] vpn,
                                  input logic [PID_W-1:0] pid, input bit use_pid);
    return e.valid && (e.vpn == vpn) && (!use_pid || (e.pid == pid));
  endfunction

  function automatic logic pid_sel(input tlb_entry_t e, input logic [PID_W-1:0] pid,
                                   input bit use_pid);
    return !use_pid || (e.pid == pid);
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter bit TAG_EN  = 1'b1,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tlb_entry_t       ent [ENTRIES],
  input  logic [VPN_W-1:0] key_vpn,
  input  logic [PID_W-1:0] key_pid,
  output logic [ENTRIES-1:0] hit_vec,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = key_eq(ent[i], key_vpn, key_pid, TAG_EN);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
  end

  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec))
    else $error("more than one entry matched");
endmodule

// File: rtl/tlb_repl.sv
module tlb_repl #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               fill_go,
  input  logic               fill_hit,
  input  logic [IDX_W-1:0]   fill_hit_idx,
  output logic [IDX_W-1:0]   fill_idx,
  output logic               replace
);
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_vec[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
  end

  assign replace  = !fill_hit && !free_found;
  assign fill_idx = fill_hit ? fill_hit_idx : (free_found ? free_idx : ptr);

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (fill_go && replace) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_go && replace) |=> $stable(ptr))
    else $error("pointer moved without a replacement");

  // R5
  ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && replace) |=> !$stable(ptr))
    else $error("pointer did not advance after replacement");
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter bit TAG_EN  = 1'b1,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_all,
  input  logic               inv_en,
  input  logic [PID_W-1:0]   inv_pid,
  input  logic               fill_go,
  input  logic [IDX_W-1:0]   fill_idx,
  input  tlb_entry_t         fill_ent,
  output tlb_entry_t         ent [ENTRIES],
  output logic [ENTRIES-1:0] valid_vec
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) ent[i] <= '0;
      else if (flush_all) ent[i].valid <= 1'b0;
      else if (inv_en && pid_sel(ent[i], inv_pid, TAG_EN)) ent[i].valid <= 1'b0;
      else if (fill_go && (fill_idx == IDX_W'(i))) ent[i] <= fill_ent;
    end
    assign valid_vec[i] = ent[i].valid;
  end

  // R7
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0))
    else $error("entries survived a flush");

  // R9
  no_rise_on_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all || inv_en) |=> ((valid_vec & ~$past(valid_vec)) == '0))
    else $error("entry became valid during invalidation");

  // R4
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && !flush_all && !inv_en) |=> valid_vec[$past(fill_idx)])
    else $error("filled slot not valid");
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter bit TAG_EN  = 1'b1,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic [FLG_W-1:0] lk_flags,
  output logic             walk_req,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [FLG_W-1:0] fill_flags,
  input  logic             base_wr,
  input  logic             inv_en,
  input  logic [PID_W-1:0] inv_pid
);
  tlb_entry_t         ent [ENTRIES];
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] lk_vec, fl_vec;
  logic [IDX_W-1:0]   lk_idx, fl_idx, fill_idx;
  logic               fl_hit, replace, fill_go;
  tlb_entry_t         fill_ent;

  tlb_cam #(.ENTRIES(ENTRIES), .TAG_EN(TAG_EN)) u_lk_cam (
    .clk(clk), .rst_n(rst_n), .ent(ent), .key_vpn(lk_vpn), .key_pid(lk_pid),
    .hit_vec(lk_vec), .hit(lk_hit), .hit_idx(lk_idx));

  tlb_cam #(.ENTRIES(ENTRIES), .TAG_EN(TAG_EN)) u_fl_cam (
    .clk(clk), .rst_n(rst_n), .ent(ent), .key_vpn(fill_vpn), .key_pid(fill_pid),
    .hit_vec(fl_vec), .hit(fl_hit), .hit_idx(fl_idx));

  assign fill_go = fill_en && !base_wr && !inv_en;

  always_comb begin
    fill_ent       = '0;
    fill_ent.valid = 1'b1;
    fill_ent.pid   = TAG_EN ? fill_pid : '0;
    fill_ent.vpn   = fill_vpn;
    fill_ent.flags = fill_flags;
    fill_ent.ppn   = fill_ppn;
  end

  tlb_repl #(.ENTRIES(ENTRIES)) u_repl (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .fill_go(fill_go),
    .fill_hit(fl_hit), .fill_hit_idx(fl_idx), .fill_idx(fill_idx), .replace(replace));

  tlb_array #(.ENTRIES(ENTRIES), .TAG_EN(TAG_EN)) u_array (
    .clk(clk), .rst_n(rst_n), .flush_all(base_wr), .inv_en(inv_en), .inv_pid(inv_pid),
    .fill_go(fill_go), .fill_idx(fill_idx), .fill_ent(fill_ent),
    .ent(ent), .valid_vec(valid_vec));

  assign lk_ppn   = lk_hit ? ent[lk_idx].ppn : '0;
  assign lk_flags = lk_hit ? ent[lk_idx].flags : '0;
  assign walk_req = lk_req && !lk_hit;

  // R6
  rewrite_in_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && fl_hit) |=> $stable(valid_vec))
    else $error("rewrite changed the set of valid slots");

  // R3
  walk_only_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> (lk_req && (lk_ppn == '0)))
    else $error("walk request without a live missing lookup");
endmodule

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_req = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [3:0] lk_pid = '0;
  logic fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [3:0] fill_pid = '0;
  logic [19:0] fill_ppn = '0;
  logic [2:0] fill_flags = '0;
  logic base_wr = 1'b0;
  logic inv_en = 1'b0;
  logic [3:0] inv_pid = '0;

  logic hit_t, hit_f, walk_t, walk_f;
  logic [19:0] ppn_t, ppn_f;
  logic [2:0] flg_t, flg_f;

  always #2.5 clk = ~clk;

  tlb_xlate #(.ENTRIES(N), .TAG_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
    .lk_hit(hit_t), .lk_ppn(ppn_t), .lk_flags(flg_t), .walk_req(walk_t),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pid(fill_pid), .fill_ppn(fill_ppn),
    .fill_flags(fill_flags), .base_wr(base_wr), .inv_en(inv_en), .inv_pid(inv_pid));

  tlb_xlate #(.ENTRIES(N), .TAG_EN(1'b0)) u_flat (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
    .lk_hit(hit_f), .lk_ppn(ppn_f), .lk_flags(flg_f), .walk_req(walk_f),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pid(fill_pid), .fill_ppn(fill_ppn),
    .fill_flags(fill_flags), .base_wr(base_wr), .inv_en(inv_en), .inv_pid(inv_pid));

  // behavioural model, index 0 = tagged, 1 = untagged
  bit m_v [2][N];
  int m_vpn [2][N];
  int m_pid [2][N];
  int m_ppn [2][N];
  int m_fl [2][N];
  int m_ptr [2];
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  function automatic int find(int m, int vpn, int pid);
    for (int i = 0; i < N; i++)
      if (m_v[m][i] && m_vpn[m][i] == vpn && (m == 1 || m_pid[m][i] == pid)) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int m = 0; m < 2; m++) begin
      m_ptr[m] = 0;
      for (int i = 0; i < N; i++) m_v[m][i] = 1'b0;
    end
  endtask

  task automatic model_edge();
    for (int m = 0; m < 2; m++) begin
      if (base_wr) begin
        for (int i = 0; i < N; i++) m_v[m][i] = 1'b0;
      end else if (inv_en) begin
        for (int i = 0; i < N; i++)
          if (m == 1 || m_pid[m][i] == int'(inv_pid)) m_v[m][i] = 1'b0;
      end else if (fill_en) begin
        int slot;
        slot = find(m, int'(fill_vpn), int'(fill_pid));
        if (slot < 0)
          for (int i = N - 1; i >= 0; i--) if (!m_v[m][i]) slot = i;
        if (slot < 0) begin
          slot = m_ptr[m];
          m_ptr[m] = (m_ptr[m] + 1) % N;
        end
        m_v[m][slot] = 1'b1;
        m_vpn[m][slot] = int'(fill_vpn);
        m_pid[m][slot] = (m == 1) ? 0 : int'(fill_pid);
        m_ppn[m][slot] = int'(fill_ppn);
        m_fl[m][slot] = int'(fill_flags);
      end
    end
  endtask

  task automatic compare(string tag);
    for (int m = 0; m < 2; m++) begin
      int k;
      logic [24:0] exp_v, got_v;
      k = find(m, int'(lk_vpn), int'(lk_pid));
      exp_v = {(k >= 0), (k >= 0) ? m_ppn[m][k][19:0] : 20'h0,
               (k >= 0) ? m_fl[m][k][2:0] : 3'h0, lk_req && (k < 0)};
      got_v = (m == 0) ? {hit_t, ppn_t, flg_t, walk_t} : {hit_f, ppn_f, flg_f, walk_f};
      compared++;
      if (got_v !== exp_v) begin
        mismatched++;
        $display("FAIL %s %s vpn=%0d pid=%0d got={hit,ppn,flags,walk}=%h exp=%h",
                 tag, (m == 0) ? "tagged" : "untagged", lk_vpn, lk_pid, got_v, exp_v);
      end
    end
  endtask

  // drive at negedge, compare, then apply model at posedge
  task automatic cyc(string tag);
    #1;
    compare(tag);
    @(posedge clk);
    if (rst_n) model_edge(); else model_reset();
    @(negedge clk);
  endtask

  task automatic quiet();
    fill_en = 1'b0; base_wr = 1'b0; inv_en = 1'b0;
  endtask

  task automatic fill(int vpn, int pid, int ppn, int fl, string tag);
    quiet();
    fill_en = 1'b1; fill_vpn = 20'(vpn); fill_pid = 4'(pid);
    fill_ppn = 20'(ppn); fill_flags = 3'(fl);
    cyc(tag);
    fill_en = 1'b0;
  endtask

  task automatic look(int vpn, int pid, string tag);
    quiet();
    lk_req = 1'b1; lk_vpn = 20'(vpn); lk_pid = 4'(pid);
    cyc(tag);
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    cyc("R1"); cyc("R1");
    rst_n = 1'b1;
    // R1: empty after reset
    look(5, 1, "R1");
    look(0, 0, "R1");
    lk_req = 1'b0; cyc("R3");
    // R4 and R2: fills land, hits carry ppn and flags
    fill(5, 1, 100, 3'b011, "R4");
    look(5, 1, "R2");
    fill(7, 1, 200, 3'b100, "R4");
    look(7, 1, "R2");
    look(6, 1, "R3");
    // R10: other process, same page
    look(5, 2, "R10");
    // R6: tagged adds entry, untagged rewrites in place
    fill(5, 2, 300, 3'b110, "R6");
    look(5, 2, "R6");
    look(5, 1, "R6");
    fill(7, 1, 201, 3'b001, "R6");
    look(7, 1, "R6");
    // R7: base write flushes all
    quiet(); base_wr = 1'b1; cyc("R7"); base_wr = 1'b0;
    look(5, 1, "R7"); look(5, 2, "R7"); look(7, 1, "R7");
    // R5: overfill forces round-robin replacement and wrap
    for (int i = 0; i < 40; i++) fill(100 + i, 1 + (i % 2), 1000 + i, i % 8, "R5");
    for (int i = 0; i < 40; i++) look(100 + i, 1 + (i % 2), "R5");
    for (int i = 0; i < 40; i++) fill(200 + i, 3, 2000 + i, i % 8, "R5");
    for (int i = 0; i < 40; i++) look(200 + i, 3, "R5");
    // R8: selective invalidate
    for (int i = 0; i < 16; i++) fill(300 + i, 1 + (i % 2), 3000 + i, 5, "R8");
    quiet(); inv_en = 1'b1; inv_pid = 4'd1; cyc("R8"); inv_en = 1'b0;
    for (int i = 0; i < 16; i++) look(300 + i, 1 + (i % 2), "R8");
    for (int i = 0; i < 4; i++) fill(400 + i, 1, 4000 + i, 2, "R8");
    for (int i = 0; i < 4; i++) look(400 + i, 1, "R8");
    // R9: fill colliding with flush or invalidate is dropped
    quiet(); fill_en = 1'b1; fill_vpn = 20'd500; fill_pid = 4'd2; fill_ppn = 20'd55;
    base_wr = 1'b1; cyc("R9"); quiet();
    look(500, 2, "R9");
    fill(501, 2, 56, 1, "R9");
    quiet(); fill_en = 1'b1; fill_vpn = 20'd502; fill_pid = 4'd3; fill_ppn = 20'd57;
    inv_en = 1'b1; inv_pid = 4'd9; cyc("R9"); quiet();
    look(502, 3, "R9"); look(501, 2, "R9");
    // mixed traffic
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      quiet();
      lk_req = 1'($urandom_range(0, 1));
      lk_vpn = 20'($urandom_range(0, 47));
      lk_pid = 4'($urandom_range(0, 3));
      if (r < 55) begin
        fill_en = 1'b1;
        fill_vpn = 20'($urandom_range(0, 47));
        fill_pid = 4'($urandom_range(0, 3));
        fill_ppn = 20'($urandom);
        fill_flags = 3'($urandom);
      end
      if (r % 97 == 1) base_wr = 1'b1;
      if (r % 41 == 2) begin inv_en = 1'b1; inv_pid = 4'($urandom_range(0, 3)); end
      cyc("R2");
    end
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog expired: got running, expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule